// File: doc/BRIEF.md
# Helicity Window Side-Channel Tagger

The tagger marks each accepted data trigger with the helicity window it belongs to. A single-cycle window-start pulse opens every new helicity window. On that edge the block increments a window counter and samples the helicity level. Both values go into one holding register, so the two always describe the same window. When a data trigger arrives, the block registers a side-channel word built from that holding register. If the trigger lands in the same cycle as a window start, the word is built from the values of the window that is just opening.

Every window start also produces a helicity-window trigger pulse. A shift line of sampled helicity bits gives a delayed-helicity output, and the delay in windows is programmable. A control input can block data triggers completely, so that only helicity-window triggers leave the block.

Top module: `hel_tagger`

## Requirements
- R1: The side-channel word `side_o` carries the window count in bits 25:16 and the helicity bit in bit 3. Every other bit of the word reads as zero.
- R2: The window count resets to 0 and increments by one on each cycle where `win_start_i` is high. It wraps from 1023 to 0.
- R3: A data trigger that follows window start N reports the count and the helicity of window N together. It never reports a new count paired with the previous window's helicity.
- R4: A data trigger in the same cycle as `win_start_i` is tagged with the new window's count and with the `hel_i` level of that cycle.
- R5: `htrig_o` pulses high for one cycle, one cycle after every `win_start_i`. This includes the first window start after reset.
- R6: An accepted `dtrig_i` gives a one-cycle `dtrig_o` one cycle later, with `side_o` valid in that cycle. `side_o` holds its value until the next accepted trigger.
- R7: While `data_trig_dis_i` is high, `dtrig_i` is ignored: `dtrig_o` stays low and `side_o` is unchanged. Window counting and `htrig_o` continue as normal.
- R8: `hel_dly_o` equals the helicity sampled at the window start D windows before the most recent one, where D is the programmed delay. D=0 gives the current window's helicity. Positions with no history read 0.
- R9: The delay D resets to 8. A pulse on `dly_ld_i` loads D from `dly_val_i` (range 0 to 15), and the new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start_i | input | 1 | Helicity window start pulse |
| hel_i | input | 1 | Helicity level |
| dtrig_i | input | 1 | Data trigger request |
| data_trig_dis_i | input | 1 | Blocks data triggers when high |
| dly_ld_i | input | 1 | Load strobe for the delay |
| dly_val_i | input | 4 | New delay in windows |
| dtrig_o | output | 1 | Tagged data trigger pulse |
| side_o | output | 32 | Side-channel word |
| htrig_o | output | 1 | Helicity-window trigger pulse |
| hel_dly_o | output | 1 | Delayed helicity |

## Verification
The hardest case to reach is a data trigger that lands exactly on a window start, or one cycle after it, with the helicity level flipping at that boundary. This is the case where a count and a helicity bit from different windows could be paired. The bench steps the ports one cycle at a time and places triggers on, and just after, window starts whose helicity differs from the previous window's. A long run of back-to-back window starts drives the counter through its wrap. Several delay settings are then checked against a modelled history of sampled helicity.

// File: rtl/hel_tagger.sv
module hel_tagger #(
  parameter int CNT_W   = 10,
  parameter int CNT_LSB = 16,
  parameter int HEL_POS = 3,
  parameter int WORD_W  = 32,
  parameter int DLY_W   = 4,
  parameter int DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_start_i,
  input  logic              hel_i,
  input  logic              dtrig_i,
  input  logic              data_trig_dis_i,
  input  logic              dly_ld_i,
  input  logic [DLY_W-1:0]  dly_val_i,
  output logic              dtrig_o,
  output logic [WORD_W-1:0] side_o,
  output logic              htrig_o,
  output logic              hel_dly_o
);

  localparam int DEPTH = 1 << DLY_W;

  logic [CNT_W-1:0]  cnt_q;
  logic              hel_q;
  logic [DEPTH-1:0]  line_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  cnt_nx;
  logic [WORD_W-1:0] word_nx;
  logic              take;

  assign cnt_nx = cnt_q + CNT_W'(1);
  assign take   = dtrig_i & ~data_trig_dis_i;

  always_comb begin
    word_nx = '0;
    word_nx[CNT_LSB +: CNT_W] = win_start_i ? cnt_nx : cnt_q;
    word_nx[HEL_POS]          = win_start_i ? hel_i  : hel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hel_q  <= 1'b0;
      line_q <= '0;
    end else if (win_start_i) begin
      cnt_q  <= cnt_nx;
      hel_q  <= hel_i;
      line_q <= {line_q[DEPTH-2:0], hel_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dly_q <= DLY_W'(DLY_RST);
    else if (dly_ld_i) dly_q <= dly_val_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtrig_o <= 1'b0;
      htrig_o <= 1'b0;
      side_o  <= '0;
    end else begin
      dtrig_o <= take;
      htrig_o <= win_start_i;
      if (take) side_o <= word_nx;
    end
  end

  assign hel_dly_o = line_q[dly_q];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))); // R2
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start_i |=> $stable(cnt_q) && $stable(hel_q)); // R3
  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dtrig_o |-> side_o[CNT_LSB +: CNT_W] == cnt_q && side_o[HEL_POS] == hel_q); // R3
  AST_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && win_start_i) |=> side_o[HEL_POS] == $past(hel_i)); // R4
  AST_HTRIG: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_i |=> htrig_o); // R5
  AST_DIS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    data_trig_dis_i |=> !dtrig_o && $stable(side_o)); // R7
  AST_DLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dly_ld_i |=> dly_q == $past(dly_val_i)); // R9

endmodule

// File: tb/hel_tagger_tb.sv
module hel_tagger_tb;
  logic clk = 0, rst_n = 0;
  logic win_start_i = 0, hel_i = 0, dtrig_i = 0, data_trig_dis_i = 0, dly_ld_i = 0;
  logic [3:0] dly_val_i = 0;
  logic dtrig_o, htrig_o, hel_dly_o;
  logic [31:0] side_o;

  int checks = 0, fails = 0;
  logic [9:0]  m_cnt;
  logic        m_hel;
  logic [15:0] m_hist;
  logic [3:0]  m_dly;
  logic [31:0] m_side;

  always #5 clk = ~clk;

  hel_tagger u_dut (.clk(clk), .rst_n(rst_n), .win_start_i(win_start_i), .hel_i(hel_i),
    .dtrig_i(dtrig_i), .data_trig_dis_i(data_trig_dis_i), .dly_ld_i(dly_ld_i),
    .dly_val_i(dly_val_i), .dtrig_o(dtrig_o), .side_o(side_o), .htrig_o(htrig_o),
    .hel_dly_o(hel_dly_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [9:0] c, input logic h);
    mk = '0;
    mk[25:16] = c;
    mk[3] = h;
  endfunction

  task automatic step(input logic ws, input logic h, input logic dt);
    logic acc;
    win_start_i = ws; hel_i = h; dtrig_i = dt;
    acc = dt & ~data_trig_dis_i;
    @(posedge clk); #1;
    if (ws) begin
      m_cnt = m_cnt + 10'd1;
      m_hel = h;
      m_hist = {m_hist[14:0], h};
    end
    if (acc) m_side = mk(m_cnt, m_hel);
    if (dly_ld_i) m_dly = dly_val_i;
    win_start_i = 0; dtrig_i = 0; dly_ld_i = 0;
    chk("R5 htrig", {31'b0, htrig_o}, {31'b0, ws});
    chk(data_trig_dis_i ? "R7 dtrig" : "R6 dtrig", {31'b0, dtrig_o}, {31'b0, acc});
    chk("R1/R3 side", side_o, m_side);
    chk("R8 hel_dly", {31'b0, hel_dly_o}, {31'b0, m_hist[m_dly]});
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    m_cnt = 0; m_hel = 0; m_hist = 0; m_dly = 8; m_side = 0;
    chk("R6 reset dtrig", {31'b0, dtrig_o}, 0);
    chk("R5 reset htrig", {31'b0, htrig_o}, 0);
    chk("R1 reset side", side_o, 0);
  endtask

  task automatic t_first_window;
    step(0, 0, 1);
    chk("R2 count before window", {22'b0, side_o[25:16]}, 0);
    step(1, 1, 0);
    step(0, 0, 1);
    chk("R5 R3 first window count", {22'b0, side_o[25:16]}, 1);
    chk("R3 first window hel", {31'b0, side_o[3]}, 1);
  endtask

  task automatic t_basic;
    for (int w = 0; w < 12; w++) begin
      step(1, w[0] ^ w[2], 0);
      step(0, 0, 1);
      step(0, 1, 0);
      step(0, 0, 1);
    end
  endtask

  task automatic t_close;
    for (int w = 0; w < 10; w++) begin
      step(1, ~m_hel, 1);
      chk("R4 coincident hel", {31'b0, side_o[3]}, {31'b0, m_hel});
      step(1, ~m_hel, 0);
      step(0, m_hel, 1);
      chk("R3 next-cycle pair", side_o, mk(m_cnt, m_hel));
    end
  endtask

  task automatic t_wrap;
    for (int w = 0; w < 1030; w++) step(1, w[1], (w % 97) == 0);
    step(0, 0, 1);
    chk("R2 wrapped count", side_o, mk(m_cnt, m_hel));
    step(1, 0, 1);
    chk("R2 count field bounds", side_o & ~32'h03FF_0008, 0);
  endtask

  task automatic t_disable;
    logic [31:0] held;
    step(0, 0, 1);
    held = side_o;
    data_trig_dis_i = 1;
    step(0, 0, 1);
    step(1, ~m_hel, 1);
    chk("R7 side held", side_o, held);
    step(1, ~m_hel, 1);
    data_trig_dis_i = 0;
    step(0, 0, 1);
    chk("R7 count kept running", side_o, mk(m_cnt, m_hel));
  endtask

  task automatic t_delay;
    for (int w = 0; w < 20; w++) step(1, w[0] ^ w[3], 0);
    for (int d = 0; d < 16; d += 5) begin
      dly_val_i = 4'(d); dly_ld_i = 1;
      step(0, 0, 0);
      chk("R9 delay loaded", {31'b0, hel_dly_o}, {31'b0, m_hist[d]});
      for (int w = 0; w < 6; w++) step(1, w[1], 0);
    end
    dly_val_i = 0; dly_ld_i = 1;
    step(1, 1, 0);
    step(0, 0, 0);
    chk("R8 zero delay", {31'b0, hel_dly_o}, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_window();
    t_basic();
    t_close();
    t_disable();
    t_wrap();
    t_delay();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule